// File: doc/BRIEF.md
# FFT Bin Denormalizer and Power Unit

This block sits directly behind a streaming FFT whose bins carry a shared block exponent. It accepts at most one complex bin per clock. Each bin has signed real and imaginary parts, a signed exponent, a valid flag and a start-of-frame flag. The block turns each bin into full-scale fixed-point values. It shifts both parts left by the amount the exponent asks for, using one registered selection per bin. It also computes the bin's power as the sum of the squares of the scaled parts, and labels the bin with a signed frequency index. Indices in the upper half of the frame are folded into negative frequencies.

The stream carries no backpressure. When the FFT pauses and drops its valid flag, the block produces nothing for the matching cycles. All results of one bin leave together, two clocks after the bin was accepted.

A two-state controller, `ST_HUNT` and `ST_FRAME`, tracks frame alignment.
- `ST_HUNT` is the state after reset, before any frame start has been seen. Bins that arrive in this state are discarded.
- The transition `frame_open` is taken on a valid bin that carries the start flag. It moves the controller to `ST_FRAME`, and that bin becomes index 0.
- In `ST_FRAME` three transitions are possible, and each keeps the controller in `ST_FRAME`:
  - `advance` steps the bin counter.
  - `wrap` returns the counter to 0 after bin N-1.
  - `resync` forces the counter back to 0 whenever a valid start flag arrives.

Top module: `fft_bin_power`

## Requirements
- R1: While reset is high, and in the first cycle after it, out_valid is low; the first accepted bin after reset must carry a start flag.
- R2: A bin is accepted when in_valid is high and either the controller is in ST_FRAME or in_sof is high. out_valid is high exactly two clocks after an accepted bin and low two clocks after any cycle with no accepted bin.
- R3: For an exponent e with -MAX_SHIFT <= e <= -1 (MAX_SHIFT = OUT_W - DATA_W, 12 by default), out_re and out_im equal the sign-extended inputs multiplied by 2^(-e), with zeros in the low bits. Both parts use the same exponent.
- R4: An exponent of zero or any positive value applies no shift: out_re and out_im equal the sign-extended inputs.
- R5: An exponent below -MAX_SHIFT saturates the shift at MAX_SHIFT. The exponent is EXP_W = 6 bits, two's complement.
- R6: out_power equals out_re squared plus out_im squared for the same bin, as an unsigned 2*OUT_W-bit value. It carries no history from other bins.
- R7: For bin counter value k < N/2, out_freq_idx is +k. For k >= N/2, out_freq_idx is k - N. Both are written as N_LOG2-bit two's complement.
- R8: A valid bin with in_sof high gets k = 0, both from ST_HUNT and in the middle of a frame (resync). The next accepted bin gets k = 1.
- R9: k advances by one on each accepted bin only, so stall cycles do not advance it. After bin N-1 the next accepted bin without a start flag gets k = 0.
- R10: Valid bins arriving in ST_HUNT, before any start flag, produce no output (out_valid stays low two clocks later).
- R11: in_sof high while in_valid is low is ignored: it neither opens a frame nor resets k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bin present this cycle |
| in_sof | input | 1 | Input bin is the first of a frame |
| in_re | input | DATA_W | Signed real part of the bin |
| in_im | input | DATA_W | Signed imaginary part of the bin |
| in_exp | input | EXP_W | Signed block exponent of the bin |
| out_valid | output | 1 | Output bin present this cycle |
| out_re | output | OUT_W | Signed denormalized real part |
| out_im | output | OUT_W | Signed denormalized imaginary part |
| out_power | output | 2*OUT_W | Unsigned re squared plus im squared |
| out_freq_idx | output | N_LOG2 | Signed frequency index of the bin |

## Verification
The assertions take for granted that in_valid and in_sof are held low throughout reset, so the two-cycle input history they keep starts from a known idle value. They also assume that in_re and in_im are any DATA_W-bit values, including the most negative one, and that in_exp may be any 6-bit pattern. The bench drives only defined values, holds every input idle during reset, and changes inputs only on the falling clock edge. It deliberately reaches the most negative data at the largest shift, every saturating exponent, and positive exponents.

// File: rtl/fft_bin_power_pkg.sv
package fft_bin_power_pkg;

    typedef enum logic [0:0] {
        ST_HUNT  = 1'b0,
        ST_FRAME = 1'b1
    } frame_state_t;

endpackage

// File: rtl/fbp_bin_counter.sv
module fbp_bin_counter
    import fft_bin_power_pkg::*;
#(
    parameter int N_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    output logic              accept,
    output logic [N_LOG2-1:0] bin_k
);

    localparam logic [N_LOG2-1:0] LAST_K = {N_LOG2{1'b1}};

    frame_state_t     state_q;
    frame_state_t     state_d;
    logic [N_LOG2-1:0] cnt_q;
    logic [N_LOG2-1:0] cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // next state, acceptance and bin number
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        bin_k   = cnt_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_HUNT: begin
                if (in_valid && in_sof) begin
                    // frame_open
                    state_d = ST_FRAME;
                    accept  = 1'b1;
                    bin_k   = '0;
                    cnt_d   = {{(N_LOG2-1){1'b0}}, 1'b1};
                end
            end
            ST_FRAME: begin
                if (in_valid) begin
                    accept = 1'b1;
                    if (in_sof) begin
                        // resync
                        bin_k = '0;
                        cnt_d = {{(N_LOG2-1){1'b0}}, 1'b1};
                    end else if (cnt_q == LAST_K) begin
                        // wrap
                        cnt_d = '0;
                    end else begin
                        // advance
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_HUNT;
            end
        endcase
    end

endmodule

// File: rtl/fbp_denorm.sv
module fbp_denorm #(
    parameter int DATA_W = 12,
    parameter int OUT_W  = 24,
    parameter int EXP_W  = 6,
    parameter int N_LOG2 = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     accept,
    input  logic [N_LOG2-1:0]        bin_k,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    input  logic signed [EXP_W-1:0]  in_exp,
    output logic                     s1_valid,
    output logic signed [OUT_W-1:0]  s1_re,
    output logic signed [OUT_W-1:0]  s1_im,
    output logic signed [N_LOG2-1:0] s1_idx
);

    localparam int MAX_SHIFT = OUT_W - DATA_W;
    localparam int SH_W      = $clog2(MAX_SHIFT + 1);
    localparam int HALF      = 1 << (N_LOG2 - 1);
    localparam logic [N_LOG2:0] FULL = (N_LOG2+1)'(1 << N_LOG2);

    logic [EXP_W:0]          mag;
    logic [SH_W-1:0]         shamt;
    logic signed [OUT_W-1:0] ext_re;
    logic signed [OUT_W-1:0] ext_im;
    logic [N_LOG2:0]         fold;

    // shift amount picked by exponent sign and size
    always_comb begin
        mag   = (EXP_W+1)'(0) - {in_exp[EXP_W-1], in_exp};
        shamt = '0;
        unique case (in_exp[EXP_W-1])
            1'b0: shamt = '0;
            1'b1: begin
                if (mag > (EXP_W+1)'(MAX_SHIFT)) begin
                    shamt = SH_W'(MAX_SHIFT);
                end else begin
                    shamt = SH_W'(mag);
                end
            end
            default: shamt = '0;
        endcase
    end

    always_comb begin
        ext_re = {{(OUT_W-DATA_W){in_re[DATA_W-1]}}, in_re};
        ext_im = {{(OUT_W-DATA_W){in_im[DATA_W-1]}}, in_im};
        if (int'(bin_k) < HALF) begin
            fold = {1'b0, bin_k};
        end else begin
            fold = {1'b0, bin_k} - FULL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_re    <= '0;
            s1_im    <= '0;
            s1_idx   <= '0;
        end else begin
            s1_valid <= accept;
            s1_re    <= ext_re <<< shamt;
            s1_im    <= ext_im <<< shamt;
            s1_idx   <= fold[N_LOG2-1:0];
        end
    end

endmodule

// File: rtl/fbp_power_stage.sv
module fbp_power_stage #(
    parameter int OUT_W  = 24,
    parameter int N_LOG2 = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     s1_valid,
    input  logic signed [OUT_W-1:0]  s1_re,
    input  logic signed [OUT_W-1:0]  s1_im,
    input  logic signed [N_LOG2-1:0] s1_idx,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_re,
    output logic signed [OUT_W-1:0]  out_im,
    output logic [2*OUT_W-1:0]       out_power,
    output logic signed [N_LOG2-1:0] out_freq_idx
);

    localparam int PWR_W = 2 * OUT_W;

    logic signed [PWR_W-1:0] wide_re;
    logic signed [PWR_W-1:0] wide_im;
    logic signed [PWR_W-1:0] sq_re;
    logic signed [PWR_W-1:0] sq_im;
    logic [PWR_W-1:0]        pwr_sum;

    always_comb begin
        wide_re = {{OUT_W{s1_re[OUT_W-1]}}, s1_re};
        wide_im = {{OUT_W{s1_im[OUT_W-1]}}, s1_im};
        sq_re   = wide_re * wide_re;
        sq_im   = wide_im * wide_im;
        pwr_sum = $unsigned(sq_re) + $unsigned(sq_im);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_re       <= '0;
            out_im       <= '0;
            out_power    <= '0;
            out_freq_idx <= '0;
        end else begin
            out_valid    <= s1_valid;
            out_re       <= s1_re;
            out_im       <= s1_im;
            out_power    <= pwr_sum;
            out_freq_idx <= s1_idx;
        end
    end

endmodule

// File: rtl/fft_bin_power.sv
module fft_bin_power #(
    parameter int DATA_W = 12,
    parameter int OUT_W  = 24,
    parameter int EXP_W  = 6,
    parameter int N_LOG2 = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_sof,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    input  logic signed [EXP_W-1:0]  in_exp,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_re,
    output logic signed [OUT_W-1:0]  out_im,
    output logic [2*OUT_W-1:0]       out_power,
    output logic signed [N_LOG2-1:0] out_freq_idx
);

    logic                     accept;
    logic [N_LOG2-1:0]        bin_k;
    logic                     s1_valid;
    logic signed [OUT_W-1:0]  s1_re;
    logic signed [OUT_W-1:0]  s1_im;
    logic signed [N_LOG2-1:0] s1_idx;

    fbp_bin_counter #(.N_LOG2(N_LOG2)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .accept   (accept),
        .bin_k    (bin_k)
    );

    fbp_denorm #(
        .DATA_W (DATA_W),
        .OUT_W  (OUT_W),
        .EXP_W  (EXP_W),
        .N_LOG2 (N_LOG2)
    ) u_denorm (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .bin_k    (bin_k),
        .in_re    (in_re),
        .in_im    (in_im),
        .in_exp   (in_exp),
        .s1_valid (s1_valid),
        .s1_re    (s1_re),
        .s1_im    (s1_im),
        .s1_idx   (s1_idx)
    );

    fbp_power_stage #(
        .OUT_W  (OUT_W),
        .N_LOG2 (N_LOG2)
    ) u_pwr (
        .clk          (clk),
        .rst          (rst),
        .s1_valid     (s1_valid),
        .s1_re        (s1_re),
        .s1_im        (s1_im),
        .s1_idx       (s1_idx),
        .out_valid    (out_valid),
        .out_re       (out_re),
        .out_im       (out_im),
        .out_power    (out_power),
        .out_freq_idx (out_freq_idx)
    );

endmodule

// File: rtl/fft_bin_power_chk.sv
module fft_bin_power_chk #(
    parameter int DATA_W = 12,
    parameter int OUT_W  = 24,
    parameter int EXP_W  = 6,
    parameter int N_LOG2 = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     in_sof,
    input logic signed [DATA_W-1:0] in_re,
    input logic signed [EXP_W-1:0]  in_exp,
    input logic                     out_valid,
    input logic signed [OUT_W-1:0]  out_re,
    input logic signed [OUT_W-1:0]  out_im,
    input logic [2*OUT_W-1:0]       out_power,
    input logic signed [N_LOG2-1:0] out_freq_idx
);

    logic                     v_d1, v_d2, sof_d1, sof_d2;
    logic signed [DATA_W-1:0] re_d1, re_d2;
    logic signed [EXP_W-1:0]  exp_d1, exp_d2;
    logic signed [OUT_W-1:0]  re_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_d1 <= 1'b0; v_d2 <= 1'b0; sof_d1 <= 1'b0; sof_d2 <= 1'b0;
            re_d1 <= '0; re_d2 <= '0; exp_d1 <= '0; exp_d2 <= '0;
        end else begin
            v_d1 <= in_valid; v_d2 <= v_d1;
            sof_d1 <= in_sof; sof_d2 <= sof_d1;
            re_d1 <= in_re; re_d2 <= re_d1;
            exp_d1 <= in_exp; exp_d2 <= exp_d1;
        end
    end

    assign re_ext = {{(OUT_W-DATA_W){re_d2[DATA_W-1]}}, re_d2};

    // R2: no output unless a valid bin came in two clocks earlier
    a_r2_valid_needs_input: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> v_d2);

    // R4: non-negative exponent leaves the real part unshifted
    a_r4_no_shift: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !exp_d2[EXP_W-1]) |-> (out_re == re_ext));

    // R3: negative exponent fills at least the lowest bit with zero
    a_r3_low_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && exp_d2[EXP_W-1]) |-> (!out_re[0] && !out_im[0]));

    // R8: a started frame reports index zero
    a_r8_sof_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sof_d2) |-> (out_freq_idx == '0));

    // R6: nonzero data never yields zero power
    a_r6_power_nonzero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_re != '0 || out_im != '0)) |-> (out_power != '0));

endmodule

bind fft_bin_power fft_bin_power_chk #(
    .DATA_W (DATA_W),
    .OUT_W  (OUT_W),
    .EXP_W  (EXP_W),
    .N_LOG2 (N_LOG2)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_sof       (in_sof),
    .in_re        (in_re),
    .in_exp       (in_exp),
    .out_valid    (out_valid),
    .out_re       (out_re),
    .out_im       (out_im),
    .out_power    (out_power),
    .out_freq_idx (out_freq_idx)
);

// File: tb/test_fft_bin_power.sv
`timescale 1ns/1ps
module test_fft_bin_power;

    localparam int DATA_W    = 12;
    localparam int OUT_W     = 24;
    localparam int EXP_W     = 6;
    localparam int N_LOG2    = 4;
    localparam int N         = 1 << N_LOG2;
    localparam int MAX_SHIFT = OUT_W - DATA_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_sof = 1'b0;
    logic signed [DATA_W-1:0] in_re = '0;
    logic signed [DATA_W-1:0] in_im = '0;
    logic signed [EXP_W-1:0]  in_exp = '0;
    logic                     out_valid;
    logic signed [OUT_W-1:0]  out_re;
    logic signed [OUT_W-1:0]  out_im;
    logic [2*OUT_W-1:0]       out_power;
    logic signed [N_LOG2-1:0] out_freq_idx;

    always #4 clk = ~clk;

    fft_bin_power #(.DATA_W(DATA_W), .OUT_W(OUT_W), .EXP_W(EXP_W), .N_LOG2(N_LOG2)) i_fft_bin_power (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_re(in_re), .in_im(in_im), .in_exp(in_exp),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
        .out_power(out_power), .out_freq_idx(out_freq_idx)
    );

    typedef struct {
        bit     v;
        longint re;
        longint im;
        longint pwr;
        int     idx;
        string  vtag;
        string  stag;
        string  itag;
    } exp_t;

    int   n_run = 0;
    int   n_fail = 0;
    exp_t pipe0, pipe1;
    bit   seen = 0;
    int   cnt = 0;
    int   seed = 7;
    bit   done = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic exp_t model(input bit v, input bit s, input int re,
                                   input int im, input int e, input string itag_in);
        exp_t r;
        int k;
        int sh;
        r.v = 0; r.re = 0; r.im = 0; r.pwr = 0; r.idx = 0;
        r.vtag = (v && !seen && !s) ? "R10" : (s && !v) ? "R11" : "R2";
        r.stag = (e >= 0) ? "R4" : (-e > MAX_SHIFT) ? "R5" : "R3";
        r.itag = itag_in;
        if (v && (seen || s)) begin
            k = s ? 0 : cnt;
            cnt = (k + 1) % N;
            seen = 1;
            sh = (e >= 0) ? 0 : ((-e > MAX_SHIFT) ? MAX_SHIFT : -e);
            r.v = 1;
            r.re = longint'(re) * (longint'(1) << sh);
            r.im = longint'(im) * (longint'(1) << sh);
            r.pwr = r.re * r.re + r.im * r.im;
            r.idx = (k < N/2) ? k : k - N;
        end
        return r;
    endfunction

    task automatic compare_out();
        check(out_valid == pipe1.v, pipe1.vtag, "out_valid", longint'(out_valid), longint'(pipe1.v));
        if (pipe1.v && out_valid) begin
            check(longint'(out_re) == pipe1.re, pipe1.stag, "out_re", longint'(out_re), pipe1.re);
            check(longint'(out_im) == pipe1.im, pipe1.stag, "out_im", longint'(out_im), pipe1.im);
            check(longint'(out_power) == pipe1.pwr, "R6", "out_power", longint'(out_power), pipe1.pwr);
            check(int'(out_freq_idx) == pipe1.idx, pipe1.itag, "out_freq_idx",
                  longint'(out_freq_idx), longint'(pipe1.idx));
        end
    endtask

    // one clock: compare current outputs, then present the next input
    task automatic step(input bit v, input bit s, input int re, input int im,
                        input int e, input string itag);
        compare_out();
        pipe1 = pipe0;
        pipe0 = model(v, s, re, im, e, itag);
        in_valid = v;
        in_sof = s;
        in_re = re[DATA_W-1:0];
        in_im = im[DATA_W-1:0];
        in_exp = e[EXP_W-1:0];
        @(negedge clk);
    endtask

    function automatic int rnd(input int lo, input int hi);
        seed = seed * 1103515245 + 12345;
        return lo + int'((seed >>> 8) & 32'h7fff_ffff) % (hi - lo + 1);
    endfunction

    initial begin
        int i = 0;
        while (!done && i < 100000) begin
            @(posedge clk);
            i++;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", i, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        pipe0 = '{0, 0, 0, 0, 0, "R1", "R1", "R1"};
        pipe1 = pipe0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);

        // R10: bins before any start flag are dropped
        for (int j = 0; j < 3; j++) step(1, 0, 100 + j, -50, -2, "R10");
        // R11: start flag without valid is ignored
        step(0, 1, 5, 5, 0, "R11");
        step(1, 0, 9, 9, 0, "R11");
        step(0, 0, 0, 0, 0, "R11");

        // R8/R7/R9: first frame, sweep exponents including positive and saturating
        step(1, 1, 300, -200, -3, "R8");
        for (int j = 1; j < N; j++) step(1, 0, rnd(-2048, 2047), rnd(-2048, 2047), rnd(-32, 31), "R7");
        // R9: wrap without start flag
        for (int j = 0; j < N + 3; j++) step(1, 0, rnd(-2048, 2047), rnd(-2048, 2047), rnd(-14, 2), "R9");

        // R9: stalls do not advance the counter; R11 start flag during stall
        step(1, 1, 1, 1, -1, "R8");
        for (int j = 0; j < 20; j++) begin
            bit v = (rnd(0, 2) != 0);
            bit s = (!v && rnd(0, 3) == 0);
            step(v, s, rnd(-2048, 2047), rnd(-2048, 2047), rnd(-20, 3), "R9");
        end

        // R5/R3 extremes: most negative data at max and beyond-max shift
        step(1, 1, -2048, -2048, -12, "R8");
        step(1, 0, -2048, 2047, -13, "R7");
        step(1, 0, 2047, -2048, -32, "R7");
        step(1, 0, -1, 1, 31, "R7");
        step(1, 0, 0, 0, -5, "R7");
        // R8: resync mid frame
        step(1, 1, 77, -77, -4, "R8");
        step(1, 0, 78, -78, -4, "R8");
        for (int j = 0; j < 40; j++)
            step(rnd(0, 4) != 0, rnd(0, 9) == 0, rnd(-2048, 2047), rnd(-2048, 2047), rnd(-32, 31), "R7");
        // drain pipeline
        step(0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R2");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule